// File: doc/BRIEF.md
# Tick Counter Real-Time Clock with Wake Alarm

This block keeps time as a 48-bit counter that advances by one on every cycle in which the tick strobe is high. The strobe is meant to run at twice the 32768 Hz crystal rate, so 65536 counts make one second. Host software reaches the block through a byte-wide register port. It can load the counter one byte at a time, read it back coherently, program a 32-bit alarm value, and manage a control byte. The oscillator and the host bus sit outside the block. So does any conversion to calendar time.

The alarm compares its 32 bits against the upper 32 bits of the counter, so its resolution is one second. When the two are equal and the alarm is enabled, the block raises a one-cycle wake pulse for the power controller. This pulse is not an interrupt and cannot be masked as one.

The control byte carries a sticky time-valid flag. Software sets the flag after loading the time. No register write can clear it; only the backup-power reset `rst_ni` returns it to zero, so software can tell when the time was lost.

Top module: `rtc_wake_core`

## Requirements
- R1: After `rst_ni` the counter and the alarm value are zero, the control byte reads 0x30, `wake_o`, `osc_bypass_o` and `clk_buf_dis_o` are low, and `rdata_o` is 0.
- R2: Each clock cycle with `tick_i` high and no counter write adds one to the 48-bit counter. Carries ripple through all six bytes, and the counter wraps from all ones to zero.
- R3: A cycle without `tick_i` and without a counter write leaves the counter unchanged.
- R4: The counter bytes sit at addresses 0x5A to 0x5F, least significant byte at 0x5A. A write to one of them replaces only that byte. A write takes priority over a tick in the same cycle, and that tick is dropped.
- R5: Reads return data on `rdata_o` one clock after the cycle with `rd_en_i` high, and `rdata_o` holds between reads. A read of 0x5A returns the live low byte and captures the whole counter. Reads of 0x5B to 0x5F return bytes of that capture, not the live counter.
- R6: The alarm bytes sit at addresses 0x56 to 0x59 and hold counter bits 16-23, 24-31, 32-39 and 40-47 in that order. They read back as written.
- R7: With control bit 2 set, `wake_o` goes high for exactly one cycle once the counter's upper 32 bits equal the alarm value. The low 16 counter bits play no part in the match.
- R8: No wake pulse is issued while control bit 2 is clear. A pulse is not repeated while the match holds, and it is issued again only after the match has gone false and become true again.
- R9: The control register is at address 0x53. Writing 1 to bit 0 sets the time-valid flag. Writing 0 to bit 0 does not clear it; only `rst_ni` does.
- R10: Control bit 1 drives `osc_bypass_o` and bit 3 drives `clk_buf_dis_o`. Bits 4 and 5 are plain storage. Bits 6 and 7 always read 0.
- R11: Reads of any other address return 0, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Backup-power reset, active low, asynchronous |
| tick_i | input | 1 | Count strobe, one count per cycle while high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one cycle after the read strobe |
| osc_bypass_o | output | 1 | Oscillator bypass request (control bit 1) |
| clk_buf_dis_o | output | 1 | Clock buffer disable (control bit 3) |
| wake_o | output | 1 | One-cycle wake pulse on alarm match |

## Verification
A wrong counter state shows up as a mismatch on the first readback after it occurs. The bench keeps its own model of the counter and compares it with full six-byte reads after every tick burst and byte load. A broken capture on byte-0 reads shows up as stale-versus-live disagreements: the bench sets the counter one step below a carry and ticks between the byte-0 read and the upper-byte reads. A wrong match or a wrong re-arm state shows up as a missing, extra or double-width wake pulse within two clocks of the matching tick, and a monitor counts those pulses. A sticky flag that has been lost shows up on the next control read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] ADDR_CTRL     = 8'h53;
  localparam logic [7:0] ADDR_ALM_BASE = 8'h56;
  localparam logic [7:0] ADDR_CNT_BASE = 8'h5A;
  localparam logic [7:0] CTRL_RST      = 8'h30;
  localparam int BIT_VALID   = 0;
  localparam int BIT_BYPASS  = 1;
  localparam int BIT_ALM_EN  = 2;
  localparam int BIT_BUF_DIS = 3;
endpackage

// File: rtl/rtc_tick_cnt.sv
module rtc_tick_cnt #(
  parameter int W = 48
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [W/8-1:0]  wr_sel_i,
  input  logic [7:0]      wdata_i,
  output logic [W-1:0]    cnt_o
);
  localparam int NB = W / 8;

  logic [W-1:0] cnt_q, cnt_ld;

  for (genvar b = 0; b < NB; b++) begin : g_ld
    assign cnt_ld[b*8 +: 8] = wr_sel_i[b] ? wdata_i : cnt_q[b*8 +: 8];
  end

  // byte load wins over a same-cycle tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (|wr_sel_i)   cnt_q <= cnt_ld;
    else if (tick_i)      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(|wr_sel_i)) |=> (cnt_o == W'($past(cnt_o) + 1'b1)));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !(|wr_sel_i)) |=> $stable(cnt_o));
  a_r4_one_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_i));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W/8-1:0]  wr_sel_i,
  input  logic [7:0]      wdata_i,
  input  logic [W-1:0]    cnt_hi_i,
  input  logic            en_i,
  output logic [W-1:0]    alarm_o,
  output logic            wake_o
);
  localparam int NB = W / 8;

  logic [W-1:0] alarm_q;
  logic         match_c, fired_q, wake_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         alarm_q[b*8 +: 8] <= '0;
      else if (wr_sel_i[b]) alarm_q[b*8 +: 8] <= wdata_i;
    end
  end

  assign match_c = (alarm_q == cnt_hi_i);

  // fired_q blocks repeats until the match drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q  <= en_i && match_c && !fired_q;
      fired_q <= match_c && (fired_q || en_i);
    end
  end

  assign alarm_o = alarm_q;
  assign wake_o  = wake_q;

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  a_r8_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(en_i));
  a_r7_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(alarm_o == cnt_hi_i));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctrl_o
);
  logic [7:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (wr_i) ctrl_q <= {2'b00, wdata_i[5:1], ctrl_q[BIT_VALID] | wdata_i[BIT_VALID]};
  end

  assign ctrl_o = ctrl_q;

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[BIT_VALID] |=> ctrl_o[BIT_VALID]);
  a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7:6] == 2'b00);
endmodule

// File: rtl/rtc_wake_core.sv
module rtc_wake_core
  import rtc_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int ALM_W = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       osc_bypass_o,
  output logic       clk_buf_dis_o,
  output logic       wake_o
);
  localparam int CNT_NB  = CNT_W / 8;
  localparam int ALM_NB  = ALM_W / 8;
  localparam int ALM_LSB = CNT_W - ALM_W;

  logic [CNT_NB-1:0] cnt_sel;
  logic [ALM_NB-1:0] alm_sel;
  logic              ctrl_sel;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-9:0]  snap_q;
  logic [ALM_W-1:0]  alarm;
  logic [7:0]        ctrl, rd_val, rdata_q;

  for (genvar b = 0; b < CNT_NB; b++) begin : g_cnt_sel
    assign cnt_sel[b] = wr_en_i && (addr_i == ADDR_CNT_BASE + 8'(b));
  end
  for (genvar b = 0; b < ALM_NB; b++) begin : g_alm_sel
    assign alm_sel[b] = wr_en_i && (addr_i == ADDR_ALM_BASE + 8'(b));
  end
  assign ctrl_sel = wr_en_i && (addr_i == ADDR_CTRL);

  rtc_tick_cnt #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .wr_sel_i (cnt_sel),
    .wdata_i,
    .cnt_o    (cnt)
  );

  rtc_alarm #(.W(ALM_W)) u_alarm (
    .clk_i, .rst_ni,
    .wr_sel_i (alm_sel),
    .wdata_i,
    .cnt_hi_i (cnt[CNT_W-1:ALM_LSB]),
    .en_i     (ctrl[BIT_ALM_EN]),
    .alarm_o  (alarm),
    .wake_o
  );

  rtc_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .wr_i    (ctrl_sel),
    .wdata_i,
    .ctrl_o  (ctrl)
  );

  always_comb begin
    rd_val = '0;
    if (addr_i == ADDR_CTRL) rd_val = ctrl;
    for (int b = 0; b < ALM_NB; b++)
      if (addr_i == ADDR_ALM_BASE + 8'(b)) rd_val = alarm[b*8 +: 8];
    if (addr_i == ADDR_CNT_BASE) rd_val = cnt[7:0];
    for (int b = 1; b < CNT_NB; b++)
      if (addr_i == ADDR_CNT_BASE + 8'(b)) rd_val = snap_q[(b-1)*8 +: 8];
  end

  // byte-0 read freezes the upper bytes for the rest of the sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      snap_q  <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rd_val;
      if (addr_i == ADDR_CNT_BASE) snap_q <= cnt[CNT_W-1:8];
    end
  end

  assign rdata_o       = rdata_q;
  assign osc_bypass_o  = ctrl[BIT_BYPASS];
  assign clk_buf_dis_o = ctrl[BIT_BUF_DIS];

  a_r5_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  a_r11_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(|cnt_sel) && !(|alm_sel) && !ctrl_sel) |=> $stable(alarm) && $stable(ctrl));
endmodule

// File: tb/rtc_wake_core_tb.sv
module rtc_wake_core_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic osc_byp, buf_dis, wake;

  int n_chk = 0, n_bad = 0, wake_cnt = 0;
  logic wake_prev = 1'b0;
  logic [47:0] m_cnt = '0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rtc_wake_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .osc_bypass_o(osc_byp),
    .clk_buf_dis_o(buf_dis), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // wake monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && wake) wake_cnt++;
    if (rst_n && wake && wake_prev) begin
      n_chk++; n_bad++;
      $display("FAIL R7: wake width got 2+ expected 1");
    end
    wake_prev <= wake;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
      m_cnt = m_cnt + 48'(n);
    end
  endtask

  task automatic set_cnt(input logic [47:0] v);
    for (int b = 0; b < 6; b++) wr(8'h5A + 8'(b), v[b*8 +: 8]);
    m_cnt = v;
  endtask

  task automatic rd_cnt(output logic [47:0] v);
    logic [7:0] d;
    for (int b = 0; b < 6; b++) begin
      rd(8'h5A + 8'(b), d);
      v[b*8 +: 8] = d;
    end
  endtask

  task automatic set_alarm(input logic [31:0] a);
    for (int b = 0; b < 4; b++) wr(8'h56 + 8'(b), a[b*8 +: 8]);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0]  d;
    logic [47:0] v;
    logic [31:0] a;
    int          w0;
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 wake", wake, 1'b0);
    chk("R1 outputs", {osc_byp, buf_dis}, 2'b00);
    rd(8'h53, d); chk("R1 ctrl", d, 8'h30);
    rd_cnt(v); chk("R1 counter", v, 48'h0);
    for (int b = 0; b < 4; b++) begin rd(8'h56 + 8'(b), d); chk("R1 alarm", d, 8'h00); end

    // R2 random tick bursts
    for (int i = 0; i < 6; i++) begin
      ticks(int'($urandom_range(1, 60)));
      rd_cnt(v); chk("R2 count", v, m_cnt);
      // R3 idle cycles leave the count alone
      repeat (int'($urandom_range(1, 9))) @(negedge clk);
      rd_cnt(v); chk("R3 hold", v, m_cnt);
    end

    // R2 full carry and wrap
    set_cnt(48'hFFFF_FFFF_FFFE); ticks(3);
    rd_cnt(v); chk("R2 wrap", v, 48'h0000_0000_0001);
    set_cnt(48'h00FF_FFFF_FFFF); ticks(1);
    rd_cnt(v); chk("R2 carry", v, 48'h0100_0000_0000);

    // R4 single byte loads
    for (int i = 0; i < 6; i++) begin
      int k = int'($urandom_range(0, 5));
      set_cnt({$urandom, 16'($urandom)});
      d = 8'($urandom);
      wr(8'h5A + 8'(k), d);
      m_cnt[k*8 +: 8] = d;
      rd_cnt(v); chk("R4 byte load", v, m_cnt);
    end
    // R4 write beats tick in the same cycle
    set_cnt(48'h1234_5678_9ABC);
    @(negedge clk); wr_en = 1'b1; tick = 1'b1; addr = 8'h5C; wdata = 8'h42;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    m_cnt[23:16] = 8'h42;
    rd_cnt(v); chk("R4 write priority", v, m_cnt);

    // R5 capture on byte-0 read
    set_cnt(48'h0000_0000_FFFF);
    rd(8'h5A, d); chk("R5 live low byte", d, 8'hFF);
    ticks(5);
    rd(8'h5B, d); chk("R5 captured byte1", d, 8'hFF);
    rd(8'h5C, d); chk("R5 captured byte2", d, 8'h00);
    rd_cnt(v); chk("R5 fresh capture", v, 48'h0000_0001_0004);
    repeat (4) @(negedge clk);
    chk("R5 rdata held", rdata, 8'h00);

    // R6 alarm readback
    for (int i = 0; i < 3; i++) begin
      a = $urandom;
      set_alarm(a);
      for (int b = 0; b < 4; b++) begin rd(8'h56 + 8'(b), d); chk("R6 alarm byte", d, a[b*8 +: 8]); end
    end

    // R7/R8 match, no repeat, disabled, re-arm
    for (int i = 0; i < 3; i++) begin
      a = $urandom_range(1, 32'hFFFF_FFF0);
      set_alarm(a);
      set_cnt({a, 16'h0} - 48'd3);
      wr(8'h53, 8'h34);
      w0 = wake_cnt;
      ticks(3); repeat (3) @(negedge clk);
      chk("R7 wake on match", wake_cnt - w0, 1);
      ticks(20); repeat (3) @(negedge clk);
      chk("R8 no repeat", wake_cnt - w0, 1);
      wr(8'h53, 8'h30);
      set_cnt({a, 16'h0} - 48'd2);
      ticks(5); repeat (3) @(negedge clk);
      chk("R8 disabled", wake_cnt - w0, 1);
      set_cnt({a, 16'h0} - 48'd1);
      wr(8'h53, 8'h34);
      ticks(1); repeat (3) @(negedge clk);
      chk("R8 re-arm", wake_cnt - w0, 2);
      // low 16 bits do not matter
      ticks(int'($urandom_range(100, 400))); repeat (3) @(negedge clk);
      chk("R7 low bits ignored", wake_cnt - w0, 2);
      wr(8'h53, 8'h30);
    end

    // R9/R10 control byte
    wr(8'h53, 8'h01); rd(8'h53, d); chk("R9 set flag", d, 8'h01);
    wr(8'h53, 8'h00); rd(8'h53, d); chk("R9 flag sticky", d, 8'h01);
    wr(8'h53, 8'hFE); rd(8'h53, d); chk("R10 fields", d, 8'h3F);
    chk("R10 bypass out", osc_byp, 1'b1);
    chk("R10 bufdis out", buf_dis, 1'b1);
    wr(8'h53, 8'h20); rd(8'h53, d); chk("R10 storage bits", d, 8'h21);
    chk("R10 outputs clear", {osc_byp, buf_dis}, 2'b00);

    // R11 unmapped addresses
    set_alarm(32'hA5C3_1E77);
    wr(8'h54, 8'hFF); wr(8'h55, 8'hFF); wr(8'h60, 8'hFF); wr(8'h00, 8'hFF);
    rd(8'h54, d); chk("R11 read 54", d, 8'h00);
    rd(8'h60, d); chk("R11 read 60", d, 8'h00);
    rd(8'h53, d); chk("R11 ctrl intact", d, 8'h21);
    for (int b = 0; b < 4; b++) begin rd(8'h56 + 8'(b), d); chk("R11 alarm intact", d, 8'(32'hA5C3_1E77 >> (b*8))); end

    // R9 backup reset clears the flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; m_cnt = '0;
    rd(8'h53, d); chk("R9 cleared by reset", d, 8'h30);
    rd_cnt(v); chk("R1 counter after reset", v, 48'h0);

    done = 1'b1;
    finish_run();
  end
endmodule